// File: doc/BRIEF.md
# Parallel Port Host Receiver

This block receives bytes from a host over a byte-wide parallel link that uses a strobe, busy and acknowledge handshake. It stands between the host connector and a processor. The block captures each strobed byte in hardware and raises BUSY at once. It then keeps BUSY high until the processor has read the byte and released the handshake through a register write. That write also sends a timed acknowledge pulse back to the host.

The processor reaches the block through a small register bus. It reads the captured byte and a status word, and it writes a control word and the acknowledge length. The status word shows whether the last byte was the carriage-return code (0x0D), so the processor can tell a print command from data. A print-hold bit written by the processor keeps BUSY high for as long as printing runs, whatever state the handshake is in. A strobe that arrives while BUSY is high is dropped and is recorded in a sticky overrun flag.

Top module: `pp_host_rx`

Register map (2-bit address): 0 = captured byte (read); 1 = status (read): bit0 data-valid, bit1 carriage-return, bit2 BUSY level, bit3 overrun, bit4 print-hold; 2 = control (write; a read returns print-hold in bit1): bit0 release, bit1 print-hold value, bit2 clear overrun; 3 = acknowledge length in clocks (read/write).

## Requirements
- R1: After reset, BUSY is low and the acknowledge output is high. The status reads 0 and the acknowledge length reads 8.
- R2: A falling edge on the strobe input is synchronized through two flops. The data bus is captured on the third rising clock edge after the strobe goes low. BUSY and status bit0 (data-valid) go high on that same edge, and BUSY is still low one cycle earlier.
- R3: A read of address 0 returns the captured byte and clears data-valid. A read of the status does not clear it.
- R4: Status bit1 is 1 when the last accepted byte equals 0x0D and 0 for any other byte.
- R5: Once a byte is captured, BUSY stays high until the processor writes the control register with bit0 set. The block never releases it by itself.
- R6: A release write while a byte is held drives the acknowledge output low for exactly the programmed number of clocks. BUSY falls on the same edge at which the acknowledge output returns high.
- R7: BUSY is the OR of the handshake state and the print-hold bit (control bit1). With hold set, BUSY stays high after the acknowledge ends, and writing hold to 0 drops it.
- R8: A strobe edge seen while BUSY is high leaves the captured byte unchanged and sets status bit3 (overrun). The flag stays set until a control write with bit2 set clears it.
- R9: A release write while no byte is held produces no acknowledge pulse.
- R10: An acknowledge length of 0 behaves as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data_i | input | 8 | Byte from the host |
| host_strobe_n_i | input | 1 | Active-low strobe from the host, asynchronous |
| host_busy_o | output | 1 | BUSY to the host |
| host_ack_n_o | output | 1 | Active-low acknowledge to the host |
| bus_addr_i | input | 2 | Register address |
| bus_rd_i | input | 1 | Read strobe; a data read clears data-valid |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |

## Verification
Bytes are sent one per handshake with an ordinary value, the carriage-return code, and a second strobe that arrives while the first byte is still held. These cases separate correct capture from flag tracking and from overrun rejection. The release path is run with the default, a short and a zero acknowledge length, and with print-hold set and clear. These runs show whether BUSY follows the handshake, the hold bit or both. Release writes while idle, and long waits while a byte is held, show that nothing moves without a processor write.

// File: rtl/pp_host_rx_pkg.sv
package pp_host_rx_pkg;

    localparam logic [1:0] ADR_DATA   = 2'd0;
    localparam logic [1:0] ADR_STATUS = 2'd1;
    localparam logic [1:0] ADR_CTRL   = 2'd2;
    localparam logic [1:0] ADR_ACKLEN = 2'd3;

    localparam int CTRL_RELEASE = 0;
    localparam int CTRL_HOLD    = 1;
    localparam int CTRL_CLR_OVR = 2;

    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_LATCHED = 2'd1,
        HS_ACK     = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic [2:0] rsvd;
        logic       hold;
        logic       overrun;
        logic       busy;
        logic       cr;
        logic       valid;
    } rx_status_t;

    function automatic logic is_code(input logic [7:0] b, input logic [7:0] code);
        return b == code;
    endfunction

endpackage

// File: rtl/pp_strobe_sync.sv
module pp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q[0] <= strobe_n_i;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~chain_q[STAGES-1];

    p_single_fall_r2: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);
endmodule

// File: rtl/pp_capture.sv
module pp_capture
    import pp_host_rx_pkg::*;
#(
    parameter int         DATA_W  = 8,
    parameter logic [7:0] CR_CODE = 8'h0D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rd_data_i,
    input  logic              clr_ovr_i,
    output logic              accept_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              cr_o,
    output logic              ovr_o
);
    logic reject;

    assign accept_o = fall_i & ~busy_i;
    assign reject   = fall_i & busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            valid_o <= 1'b0;
            cr_o    <= 1'b0;
            ovr_o   <= 1'b0;
        end else begin
            if (accept_o) begin
                data_o  <= data_i;
                valid_o <= 1'b1;
                cr_o    <= is_code(8'(data_i), CR_CODE);
            end else if (rd_data_i) begin
                valid_o <= 1'b0;
            end
            if (reject)         ovr_o <= 1'b1;
            else if (clr_ovr_i) ovr_o <= 1'b0;
        end
    end

    p_reject_keeps_data_r8: assert property (@(posedge clk) disable iff (rst)
        reject |=> ($stable(data_o) && ovr_o));
    p_accept_sets_valid_r2: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> valid_o);
endmodule

// File: rtl/pp_handshake.sv
module pp_handshake
    import pp_host_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic             release_i,
    input  logic [CNT_W-1:0] ack_len_i,
    output logic             hs_busy_o,
    output logic             ack_n_o
);
    hs_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                HS_IDLE:    if (accept_i) state_q <= HS_LATCHED;
                HS_LATCHED: if (release_i) begin
                    state_q <= HS_ACK;
                    cnt_q   <= ack_len_i;
                end
                HS_ACK: begin
                    if (cnt_q <= CNT_W'(1)) state_q <= HS_IDLE;
                    else                    cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= HS_IDLE;
            endcase
        end
    end

    assign hs_busy_o = state_q != HS_IDLE;
    assign ack_n_o   = state_q != HS_ACK;

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> hs_busy_o);
    p_release_acks_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_LATCHED && release_i) |=> !ack_n_o);
    p_ack_while_busy_r6: assert property (@(posedge clk) disable iff (rst)
        !ack_n_o |-> hs_busy_o);
    p_no_self_release_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_LATCHED && !release_i) |=> hs_busy_o && ack_n_o);
    p_idle_no_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_IDLE) |=> ack_n_o);
endmodule

// File: rtl/pp_host_rx.sv
module pp_host_rx
    import pp_host_rx_pkg::*;
#(
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter int         ACK_DEFAULT = 8,
    parameter logic [7:0] CR_CODE     = 8'h0D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] host_data_i,
    input  logic              host_strobe_n_i,
    output logic              host_busy_o,
    output logic              host_ack_n_o,
    input  logic [1:0]        bus_addr_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o
);
    localparam int CNT_W = DATA_W;

    logic              fall, accept, hs_busy;
    logic              valid, cr, ovr;
    logic [DATA_W-1:0] data_q;
    logic              hold_q;
    logic [CNT_W-1:0]  ack_len_q;
    logic              ctrl_wr, rel, clr_ovr, rd_data;
    rx_status_t        status;

    assign ctrl_wr = bus_wr_i && bus_addr_i == ADR_CTRL;
    assign rel     = ctrl_wr && bus_wdata_i[CTRL_RELEASE];
    assign clr_ovr = ctrl_wr && bus_wdata_i[CTRL_CLR_OVR];
    assign rd_data = bus_rd_i && bus_addr_i == ADR_DATA;

    pp_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .strobe_n_i(host_strobe_n_i), .fall_o(fall)
    );

    pp_capture #(.DATA_W(DATA_W), .CR_CODE(CR_CODE)) i_cap (
        .clk(clk), .rst(rst), .fall_i(fall), .busy_i(host_busy_o),
        .data_i(host_data_i), .rd_data_i(rd_data), .clr_ovr_i(clr_ovr),
        .accept_o(accept), .data_o(data_q), .valid_o(valid),
        .cr_o(cr), .ovr_o(ovr)
    );

    pp_handshake #(.CNT_W(CNT_W)) i_hs (
        .clk(clk), .rst(rst), .accept_i(accept), .release_i(rel),
        .ack_len_i(ack_len_q), .hs_busy_o(hs_busy), .ack_n_o(host_ack_n_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= 1'b0;
            ack_len_q <= CNT_W'(ACK_DEFAULT);
        end else begin
            if (ctrl_wr) hold_q <= bus_wdata_i[CTRL_HOLD];
            if (bus_wr_i && bus_addr_i == ADR_ACKLEN) ack_len_q <= bus_wdata_i;
        end
    end

    assign host_busy_o = hs_busy | hold_q;

    always_comb begin
        status         = '0;
        status.valid   = valid;
        status.cr      = cr;
        status.busy    = host_busy_o;
        status.overrun = ovr;
        status.hold    = hold_q;
    end

    always_comb begin
        unique case (bus_addr_i)
            ADR_DATA:   bus_rdata_o = data_q;
            ADR_STATUS: bus_rdata_o = DATA_W'(status);
            ADR_CTRL:   bus_rdata_o = DATA_W'({hold_q, 1'b0});
            default:    bus_rdata_o = ack_len_q;
        endcase
    end

    p_hold_busy_r7: assert property (@(posedge clk) disable iff (rst)
        hold_q |-> host_busy_o);
    p_hold_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !bus_wdata_i[CTRL_HOLD] && !hs_busy) |=> !host_busy_o);
endmodule

// File: tb/test_pp_host_rx.sv
`timescale 1ns/1ps
module test_pp_host_rx;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] hdata;
    logic       strobe_n;
    logic       busy, ack_n;
    logic [1:0] addr;
    logic       rd, wr;
    logic [7:0] wdata, rdata;
    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pp_host_rx i_pp_host_rx (
        .clk(clk), .rst(rst), .host_data_i(hdata), .host_strobe_n_i(strobe_n),
        .host_busy_o(busy), .host_ack_n_o(ack_n), .bus_addr_i(addr),
        .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input string req, input bit check_busy);
        @(negedge clk);
        hdata = b; strobe_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (check_busy) check(req, "busy before capture edge", busy, 0);
        @(negedge clk);
        if (check_busy) check(req, "busy after capture edge", busy, 1);
        @(negedge clk);
        strobe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic count_ack(output int n, output int busy_at_end);
        n = 0;
        @(negedge clk);
        while (!ack_n && n < 300) begin
            n++;
            @(negedge clk);
        end
        busy_at_end = busy;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1", "busy", busy, 0);
        check("R1", "ack_n", ack_n, 1);
        bus_read(2'd1, v); check("R1", "status", v, 8'h00);
        bus_read(2'd3, v); check("R1", "ack length", v, 8);
    endtask

    task automatic t_plain_byte;
        logic [7:0] v;
        int n, b;
        send_byte(8'hA5, "R2", 1'b1);
        bus_read(2'd1, v); check("R2", "status valid/busy", v & 8'h07, 8'h05);
        check("R4", "cr flag for A5", v[1], 0);
        bus_read(2'd1, v); check("R3", "status read keeps valid", v[0], 1);
        bus_read(2'd0, v); check("R3", "data", v, 8'hA5);
        bus_read(2'd1, v); check("R3", "valid after data read", v[0], 0);
        repeat (50) @(negedge clk);
        check("R5", "busy held without release", busy, 1);
        check("R5", "no ack without release", ack_n, 1);
        bus_write(2'd2, 8'h01);
        count_ack(n, b);
        check("R6", "ack length default", n, 8);
        check("R6", "busy when ack ends", b, 0);
    endtask

    task automatic t_cr_hold;
        logic [7:0] v;
        int n, b;
        send_byte(8'h0D, "R2", 1'b1);
        bus_read(2'd1, v); check("R4", "cr flag for 0D", v[1], 1);
        bus_write(2'd2, 8'h03);
        count_ack(n, b);
        check("R6", "ack with hold", n, 8);
        check("R7", "busy held by hold bit", b, 1);
        repeat (5) @(negedge clk);
        check("R7", "still busy", busy, 1);
        bus_write(2'd2, 8'h00);
        @(negedge clk);
        check("R7", "busy after hold cleared", busy, 0);
    endtask

    task automatic t_overrun;
        logic [7:0] v;
        int n, b;
        send_byte(8'h11, "R8", 1'b0);
        send_byte(8'h22, "R8", 1'b0);
        bus_read(2'd0, v); check("R8", "data kept", v, 8'h11);
        bus_read(2'd1, v); check("R8", "overrun flag", v[3], 1);
        bus_write(2'd2, 8'h05);
        count_ack(n, b);
        bus_read(2'd1, v); check("R8", "overrun cleared", v[3], 0);
        check("R8", "busy after release", busy, 0);
    endtask

    task automatic t_idle_release;
        int lows = 0;
        bus_write(2'd2, 8'h01);
        repeat (10) begin
            @(negedge clk);
            if (!ack_n) lows++;
        end
        check("R9", "ack pulses while idle", lows, 0);
        check("R9", "busy while idle", busy, 0);
    endtask

    task automatic t_lengths;
        int n, b;
        bus_write(2'd3, 8'd3);
        send_byte(8'h41, "R6", 1'b0);
        bus_write(2'd2, 8'h01);
        count_ack(n, b);
        check("R6", "ack length 3", n, 3);
        bus_write(2'd3, 8'd0);
        send_byte(8'h42, "R10", 1'b0);
        bus_write(2'd2, 8'h01);
        count_ack(n, b);
        check("R10", "ack length 0 acts as 1", n, 1);
        check("R10", "busy after short ack", b, 0);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; hdata = '0; strobe_n = 1'b1;
        addr = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain_byte();
        t_cr_hold();
        t_overrun();
        t_idle_release();
        t_lengths();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule